// File: doc/BRIEF.md
# Converter Mode Register with Alert/Busy Pin Control

This block holds the 16-bit mode word of a multi-channel data converter and turns it into the control signals the rest of the converter needs: noise-avoidance enables, an automatic sequencing enable, a doubled input range per input, and a pairing mode for each of two input pairs. Software writes and reads the word through a simple register port. The serial bus that carries those accesses is outside the block, and so is the converter datapath.

The block also drives one shared interrupt pin. A two-bit function field sets what the pin shows: nothing, the converter busy signal, or a pending alert. A polarity bit is applied last. Alert events arrive as a vector and latch into sticky status bits. One code of the function field is not a mode. It is a one-shot clear command that wipes the alert status, returns the pin to its inactive level, and leaves the field reading back as alert mode.

Top module: `cfg_alert_ctl`

## Requirements
- R1: On a synchronous reset the mode word reads 0x0000, every alert status bit and the alert flag are 0, and the pin is high, which is the inactive level for the default active-low polarity.
- R2: A write stores the data one clock later. Bit 15 always reads back as 0. When bits [2:1] of the data are not 11, every other bit reads back exactly as written.
- R3: Bits [2:1] pick the pin function. 00 holds the pin inactive. 01 makes it follow the busy input. 10 makes it assert while any alert status bit is set. The pin is registered, so it reflects the inputs and mode word of the previous cycle.
- R4: Writing 11 to bits [2:1] is a clear command. The field then reads back as 10, and all other bits are stored as in R2.
- R5: A clear command zeroes every alert status bit and the alert flag at the clock edge that takes the write. At that same edge the pin goes to the inactive level of the newly written polarity bit. An alert event in the same cycle as the clear is discarded.
- R6: Each alert event bit sets its status bit at the next edge. The bit stays set until a clear. The alert flag is the OR of all status bits.
- R7: Bit 0 sets polarity. With 1 the pin is high when asserted. With 0 the pin is low when asserted.
- R8: Bits 14, 13 and 3 are active-low enables for delayed sampling, delayed bit trials and the bus glitch filter. Each output is 1 while its bit is 0.
- R9: Pair 0 uses diff bit 8 and pseudo bit 10. Pair 1 uses diff bit 9 and pseudo bit 11. Each pair's 2-bit code is 00 for single-ended when its diff bit is 0, 01 for differential when only the diff bit is set, and 10 for pseudo-differential when both bits are set. Pair 0's code is at pair_mode[1:0] and pair 1's at [3:2].
- R10: Bits 7..4 drive range_x2[3:0] in the same order. Bit 12 drives autocycle_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current mode word |
| conv_busy | input | 1 | Converter busy indication |
| alert_evt | input | NUM_ALERT | Alert event pulses, one per source |
| alert_status | output | NUM_ALERT | Sticky alert status bits |
| alert_flag | output | 1 | OR of the alert status bits |
| irq_pin | output | 1 | Shared alert/busy pin level |
| dly_samp_en | output | 1 | Delayed sampling enabled |
| dly_trial_en | output | 1 | Delayed bit trials enabled |
| glitch_filt_en | output | 1 | Bus glitch filter enabled |
| autocycle_en | output | 1 | Automatic sequencing enabled |
| range_x2 | output | 4 | Doubled input range, one bit per input |
| pair_mode | output | 4 | Pairing code, 2 bits per input pair |

## Verification
Two things can land on the same clock edge: a clear command and a fresh alert event. The bench first leaves a status bit pending. It then drives the clear write and a different event bit in the same cycle. It expects all status bits, the flag and the pin to come out cleared, and it expects them to stay cleared for a further cycle with no event. A later event, sent on its own, must set its bit normally. That shows the clear lasts one cycle only and is not a lasting mask.

// File: rtl/cfg_alert_pkg.sv
package cfg_alert_pkg;
  localparam int CFG_W      = 16;
  localparam int NUM_PAIRS  = 2;
  localparam int NUM_RANGE  = 4;

  // bit positions decoded by neighbours
  localparam int B_POL      = 0;
  localparam int B_FN_LO    = 1;
  localparam int B_FILT_N   = 3;
  localparam int B_RANGE_LO = 4;
  localparam int B_DIFF_LO  = 8;
  localparam int B_PSEU_LO  = 10;
  localparam int B_AUTO     = 12;
  localparam int B_TRIAL_N  = 13;
  localparam int B_SAMP_N   = 14;
  localparam int B_RSVD     = 15;

  typedef enum logic [1:0] {
    PIN_NONE  = 2'b00,
    PIN_BUSY  = 2'b01,
    PIN_ALERT = 2'b10,
    PIN_CLEAR = 2'b11
  } pin_fn_e;

  typedef enum logic [1:0] {
    PAIR_SINGLE = 2'b00,
    PAIR_DIFF   = 2'b01,
    PAIR_PSEUDO = 2'b10
  } pair_mode_e;
endpackage

// File: rtl/cfg_mode_reg.sv
module cfg_mode_reg
  import cfg_alert_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] cfg_q,
  output logic             clr_cmd
);
  logic [CFG_W-1:0] cfg_d;
  pin_fn_e          fn_in;

  assign fn_in   = pin_fn_e'(wr_data[B_FN_LO +: 2]);
  assign clr_cmd = wr_en && (fn_in == PIN_CLEAR);

  always_comb begin
    cfg_d         = wr_data;
    cfg_d[B_RSVD] = 1'b0;
    if (fn_in == PIN_CLEAR) cfg_d[B_FN_LO +: 2] = PIN_ALERT;
  end

  always_ff @(posedge clk) begin
    if (rst)        cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_d;
  end

  // R2: plain write lands one cycle later with bit 15 dropped
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[B_FN_LO +: 2] != 2'b11) |=>
      (cfg_q == {1'b0, $past(wr_data[CFG_W-2:0])}));

  // R4: clear code reads back as alert mode
  a_r4_clear_readback: assert property (@(posedge clk) disable iff (rst)
    clr_cmd |=> (cfg_q[B_FN_LO +: 2] == 2'b10));
endmodule

// File: rtl/cfg_field_decode.sv
module cfg_field_decode
  import cfg_alert_pkg::*;
(
  input  logic [CFG_W-1:0]       cfg,
  output logic                   dly_samp_en,
  output logic                   dly_trial_en,
  output logic                   glitch_filt_en,
  output logic                   autocycle_en,
  output logic [NUM_RANGE-1:0]   range_x2,
  output logic [2*NUM_PAIRS-1:0] pair_mode
);
  assign dly_samp_en    = ~cfg[B_SAMP_N];
  assign dly_trial_en   = ~cfg[B_TRIAL_N];
  assign glitch_filt_en = ~cfg[B_FILT_N];
  assign autocycle_en   = cfg[B_AUTO];

  for (genvar r = 0; r < NUM_RANGE; r++) begin : g_range
    assign range_x2[r] = cfg[B_RANGE_LO + r];
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    pair_mode_e m;
    always_comb begin
      if (!cfg[B_DIFF_LO + p])     m = PAIR_SINGLE;
      else if (cfg[B_PSEU_LO + p]) m = PAIR_PSEUDO;
      else                         m = PAIR_DIFF;
    end
    assign pair_mode[2*p +: 2] = m;
  end
endmodule

// File: rtl/cfg_alert_status.sv
module cfg_alert_status #(
  parameter int NUM_ALERT = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic [NUM_ALERT-1:0] evt,
  output logic [NUM_ALERT-1:0] stat_q,
  output logic                 any_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) stat_q <= '0;
    else            stat_q <= stat_q | evt;
  end

  assign any_q = |stat_q;

  // R5: clear wins over any same-cycle event
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr |=> (stat_q == '0));

  // R6: status is sticky and takes new events
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((stat_q & $past(stat_q | evt)) == $past(stat_q | evt)));
endmodule

// File: rtl/cfg_pin_drive.sv
module cfg_pin_drive
  import cfg_alert_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] fn,
  input  logic       pol,
  input  logic       busy,
  input  logic       any_alert,
  input  logic       clr,
  input  logic       clr_pol,
  output logic       pin_q
);
  logic act;

  always_comb begin
    unique case (pin_fn_e'(fn))
      PIN_BUSY:  act = busy;
      PIN_ALERT: act = any_alert;
      default:   act = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)      pin_q <= 1'b1;
    else if (clr) pin_q <= ~clr_pol;
    else          pin_q <= pol ? act : ~act;
  end

  // R5: clear parks the pin at the inactive level of the new polarity
  a_r5_clear_pin: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pin_q == !$past(clr_pol)));

  // R3: busy mode tracks the busy input of the prior cycle
  a_r3_busy_follow: assert property (@(posedge clk) disable iff (rst)
    (!clr && fn == 2'b01) |=> (pin_q == ($past(busy) ~^ $past(pol))));
endmodule

// File: rtl/cfg_alert_ctl.sv
module cfg_alert_ctl
  import cfg_alert_pkg::*;
#(
  parameter int NUM_ALERT = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [CFG_W-1:0]       wr_data,
  output logic [CFG_W-1:0]       rd_data,
  input  logic                   conv_busy,
  input  logic [NUM_ALERT-1:0]   alert_evt,
  output logic [NUM_ALERT-1:0]   alert_status,
  output logic                   alert_flag,
  output logic                   irq_pin,
  output logic                   dly_samp_en,
  output logic                   dly_trial_en,
  output logic                   glitch_filt_en,
  output logic                   autocycle_en,
  output logic [NUM_RANGE-1:0]   range_x2,
  output logic [2*NUM_PAIRS-1:0] pair_mode
);
  logic [CFG_W-1:0] cfg_q;
  logic             clr_cmd;

  cfg_mode_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_q(cfg_q), .clr_cmd(clr_cmd)
  );

  cfg_field_decode u_dec (
    .cfg(cfg_q), .dly_samp_en(dly_samp_en), .dly_trial_en(dly_trial_en),
    .glitch_filt_en(glitch_filt_en), .autocycle_en(autocycle_en),
    .range_x2(range_x2), .pair_mode(pair_mode)
  );

  cfg_alert_status #(.NUM_ALERT(NUM_ALERT)) u_stat (
    .clk(clk), .rst(rst), .clr(clr_cmd), .evt(alert_evt),
    .stat_q(alert_status), .any_q(alert_flag)
  );

  cfg_pin_drive u_pin (
    .clk(clk), .rst(rst), .fn(cfg_q[B_FN_LO +: 2]), .pol(cfg_q[B_POL]),
    .busy(conv_busy), .any_alert(alert_flag), .clr(clr_cmd),
    .clr_pol(wr_data[B_POL]), .pin_q(irq_pin)
  );

  assign rd_data = cfg_q;
endmodule

// File: tb/cfg_alert_ctl_tb_top.sv
`timescale 1ns/1ps
module cfg_alert_ctl_tb_top;
  localparam int NA = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [15:0]   wr_data = '0;
  logic [15:0]   rd_data;
  logic          conv_busy = 1'b0;
  logic [NA-1:0] alert_evt = '0;
  logic [NA-1:0] alert_status;
  logic          alert_flag, irq_pin;
  logic          dly_samp_en, dly_trial_en, glitch_filt_en, autocycle_en;
  logic [3:0]    range_x2, pair_mode;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  cfg_alert_ctl #(.NUM_ALERT(NA)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .conv_busy(conv_busy), .alert_evt(alert_evt), .alert_status(alert_status),
    .alert_flag(alert_flag), .irq_pin(irq_pin), .dly_samp_en(dly_samp_en),
    .dly_trial_en(dly_trial_en), .glitch_filt_en(glitch_filt_en),
    .autocycle_en(autocycle_en), .range_x2(range_x2), .pair_mode(pair_mode)
  );

  // {write data, expected readback}
  localparam logic [31:0] VEC [8] = '{
    {16'h1234, 16'h1234}, {16'h8001, 16'h0001}, {16'hFFF9, 16'h7FF9},
    {16'h0006, 16'h0004}, {16'hFFFF, 16'h7FFD}, {16'h0A5A, 16'h0A5A},
    {16'h6000, 16'h6000}, {16'h0000, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // drive a write at a negedge; one posedge takes it
  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  function automatic logic [1:0] pair_exp(input logic diff, input logic pseu);
    if (!diff) return 2'b00;
    return pseu ? 2'b10 : 2'b01;
  endfunction

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 rd", rd_data, 16'h0000);
    chk("R1 status", {alert_flag, alert_status}, '0);
    chk("R1 pin", irq_pin, 1'b1);
    chk("R8 reset enables", {dly_samp_en, dly_trial_en, glitch_filt_en}, 3'b111);

    // table walk: readback and field decode
    for (int i = 0; i < 8; i++) begin
      logic [15:0] e;
      e = VEC[i][15:0];
      wr(VEC[i][31:16]);
      chk("R2/R4 readback", rd_data, e);
      chk("R8 enables", {dly_samp_en, dly_trial_en, glitch_filt_en},
          {~e[14], ~e[13], ~e[3]});
      chk("R10 range/auto", {autocycle_en, range_x2}, {e[12], e[7:4]});
      chk("R9 pairs", pair_mode, {pair_exp(e[9], e[11]), pair_exp(e[8], e[10])});
    end

    // R3/R7 busy mode, active high
    wr(16'h0003);
    conv_busy = 1'b1; step();
    chk("R3 busy hi", irq_pin, 1'b1);
    conv_busy = 1'b0; step();
    chk("R3 busy lo", irq_pin, 1'b0);
    // R7 busy mode, active low
    wr(16'h0002);
    conv_busy = 1'b1; step();
    chk("R7 busy active low", irq_pin, 1'b0);
    conv_busy = 1'b0; step();
    chk("R7 busy idle low-pol", irq_pin, 1'b1);

    // R6 alert mode active high, sticky status
    wr(16'h0005);
    alert_evt = 8'h08; step(); alert_evt = '0;
    chk("R6 status set", alert_status, 8'h08);
    chk("R6 flag", alert_flag, 1'b1);
    step();
    chk("R3 alert pin", irq_pin, 1'b1);
    alert_evt = 8'h01; step(); alert_evt = '0;
    chk("R6 sticky", alert_status, 8'h09);

    // R5 clear with active-high polarity
    wr(16'h0007);
    chk("R5 status cleared", {alert_flag, alert_status}, '0);
    chk("R5 pin inactive", irq_pin, 1'b0);
    chk("R4 clear readback", rd_data, 16'h0005);
    step();
    chk("R5 pin stays", irq_pin, 1'b0);

    // R5 clear and event in the same cycle
    alert_evt = 8'h01; step(); alert_evt = '0;
    chk("R6 pending", alert_status, 8'h01);
    alert_evt = 8'h80; wr(16'h0007); alert_evt = '0;
    chk("R5 clear wins", alert_status, 8'h00);
    step();
    chk("R5 clear wins held", {alert_flag, alert_status}, '0);
    alert_evt = 8'h10; step(); alert_evt = '0;
    chk("R6 event after clear", alert_status, 8'h10);
    step();
    chk("R3 alert pin again", irq_pin, 1'b1);

    // R3 mode none holds pin inactive despite pending alert
    wr(16'h0001);
    step();
    chk("R3 none hi-pol", irq_pin, 1'b0);
    wr(16'h0000);
    conv_busy = 1'b1; step();
    chk("R3 none lo-pol", irq_pin, 1'b1);
    // R3 busy mode ignores pending alert
    conv_busy = 1'b0;
    wr(16'h0003);
    step();
    chk("R3 busy ignores alert", irq_pin, 1'b0);
    chk("R6 still pending", alert_status, 8'h10);

    // R5 clear with active-low polarity
    wr(16'h0006);
    chk("R5 pin low-pol clear", irq_pin, 1'b1);
    chk("R4 low-pol readback", rd_data, 16'h0004);
    chk("R5 flag", alert_flag, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule